// File: doc/BRIEF.md
# UART Busy-Gated Configuration Register Bank

This block keeps the configuration state of a 16550-style serial port: the frame format register, the two bytes of the baud divisor, the modem control byte carrying the loopback switch, and the interrupt enable byte. It drives the active divisor, the frame format bits and the loopback control to the serial engine. The engine, the baud generator and the FIFOs live outside the block and report their activity through three status pins.

Software reaches the bank over a plain register bus with an address, a write strobe, write data and combinational read data. While a character is moving or the transmit FIFO holds data, the block refuses changes to the frame format and the divisor, so no frame is sent or received with a mix of old and new settings. An optional staging mode accepts those writes during activity and holds them aside. A self-clearing update command then moves them into the active set at the next point where both shift engines are idle. A build parameter selects plain compatible behaviour with no gating at all.

The bus has no back-pressure: every write is taken in the cycle its strobe is high, and a read returns data in the same cycle.

Top module: `uart_cfg_regs`

## Requirements
- R1: After reset, every register reads zero, the busy status is clear, staging mode is off, no change is pending and no update is requested.
- R2: Busy is high in exactly the cycles where `tx_active`, `rx_active` or `txf_nonempty` is high. It appears on the `busy` pin and on read bit 0 of address 7 in the same cycle.
- R3: While busy is high and staging mode is off, writes to address 3 (frame format), address 0 with access bit set (divisor low) and address 1 with access bit set (divisor high) leave the active values unchanged.
- R4: While busy is low and staging mode is off, those writes take effect on `divisor` (high byte from address 1, low byte from address 0) and on `frame_fmt` (bits 6:0 of address 3) from the next cycle.
- R5: Bit 7 of the frame format register is the divisor access bit. When it is clear, address 1 holds the interrupt enable byte, which is written regardless of busy, and address 0 reads zero.
- R6: A divisor-high write that is blocked by busy does not change the interrupt enable byte.
- R7: With staging mode on (bit 0 of address 5), frame format and divisor writes are held as pending values whether or not busy is high, and they do not change the outputs. Reads of those addresses return the pending value while a change is pending, and the active value otherwise. The divisor access bit is taken from that same visible value.
- R8: A write to address 5 with bits 1 and 0 both set requests an update, and bit 1 of address 5 reads 1 until the update is done. Once the pending values have been moved to the active set, the bit reads 0 and the pending state is cleared.
- R9: A requested update moves the pending values to the active set on the first clock edge at which `tx_active` and `rx_active` are both low, whatever `txf_nonempty` is. It never does so while either engine is active.
- R10: Bit 4 of address 4 drives `loopback` from the next cycle and is writable while busy. Setting it does not clear busy while `rx_active` stays high.
- R11: With parameter COMPAT set, frame format and divisor writes always take effect directly, whatever busy and staging mode are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| tx_active | input | 1 | Transmit engine is sending a character |
| rx_active | input | 1 | Receive engine is taking in a character |
| txf_nonempty | input | 1 | Transmit FIFO holds data |
| busy | output | 1 | Engine activity flag |
| divisor | output | 16 | Active baud divisor |
| frame_fmt | output | 7 | Active frame format bits |
| loopback | output | 1 | Loopback control |
| int_enable | output | 8 | Interrupt enable byte |

## Verification
Directed writes go in with each of the three activity sources high on its own. This shows that every source blocks the divisor and frame format on its own, and that a FIFO that is not empty blocks writes but still lets a requested update through. Blocked divisor-high writes are followed by reads of the interrupt enable byte, which tells gating apart from spilling into the neighbouring register. An update is requested while the transmitter runs and then released with only the FIFO busy, which tells the commit-at-idle rule apart from committing right away. A long run of seeded random writes, address choices and activity patterns, checked against a bench model on every cycle, mixes staging, direct writes and updates in orders that the directed cases do not reach.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;
  localparam int DATA_W = 8;
  localparam int NFIELD = 3;
  localparam int F_DLL  = 0;
  localparam int F_DLH  = 1;
  localparam int F_LCR  = 2;

  localparam logic [2:0] A_DLL_DAT = 3'd0;
  localparam logic [2:0] A_DLH_IER = 3'd1;
  localparam logic [2:0] A_LCR     = 3'd3;
  localparam logic [2:0] A_MCR     = 3'd4;
  localparam logic [2:0] A_EXT     = 3'd5;
  localparam logic [2:0] A_STAT    = 3'd7;

  localparam int LCR_ACC_BIT  = 7;
  localparam int MCR_LOOP_BIT = 4;
  localparam int EXT_CAB_BIT  = 0;
  localparam int EXT_UPD_BIT  = 1;

  typedef logic [NFIELD-1:0][DATA_W-1:0] cfg_t;
endpackage

// File: rtl/uart_cfg_busy.sv
module uart_cfg_busy #(
  parameter bit COMPAT = 1'b0
) (
  input  logic tx_active,
  input  logic rx_active,
  input  logic txf_nonempty,
  output logic busy,
  output logic gate,
  output logic engines_idle
);
  assign busy         = tx_active | rx_active | txf_nonempty;
  assign engines_idle = ~tx_active & ~rx_active;

  generate
    if (COMPAT) begin : g_nogate
      assign gate = 1'b0;
    end else begin : g_gate
      assign gate = busy;
    end
  endgenerate
endmodule

// File: rtl/uart_cfg_decode.sv
module uart_cfg_decode
  import uart_cfg_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic              wr,
  input  logic [AW-1:0]     addr,
  input  logic              acc,
  input  logic              stage_en,
  input  logic              gate,
  output logic [NFIELD-1:0] st_wr,
  output logic [NFIELD-1:0] dw_wr,
  output logic              hit_ier,
  output logic              hit_mcr,
  output logic              hit_ext
);
  logic [NFIELD-1:0] hit;

  always_comb begin
    hit        = '0;
    hit[F_LCR] = wr && (addr == AW'(A_LCR));
    hit[F_DLH] = wr && (addr == AW'(A_DLH_IER)) && acc;
    hit[F_DLL] = wr && (addr == AW'(A_DLL_DAT)) && acc;
    hit_ier    = wr && (addr == AW'(A_DLH_IER)) && !acc;
    hit_mcr    = wr && (addr == AW'(A_MCR));
    hit_ext    = wr && (addr == AW'(A_EXT));
    st_wr      = stage_en ? hit : '0;
    dw_wr      = (!stage_en && !gate) ? hit : '0;
  end
endmodule

// File: rtl/uart_cfg_stage.sv
module uart_cfg_stage
  import uart_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cfg_t              act,
  input  logic [NFIELD-1:0] st_wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              upd_set,
  input  logic              engines_idle,
  output cfg_t              vis,
  output logic              pend_flag,
  output logic              upd_req,
  output logic              commit
);
  cfg_t pend_q;
  cfg_t base;

  assign base   = pend_flag ? pend_q : act;
  assign vis    = base;
  assign commit = upd_req && engines_idle;

  generate
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
      always_ff @(posedge clk) begin
        if (!rst_n)          pend_q[f] <= '0;
        else if (st_wr[f])   pend_q[f] <= wdata;
        else if (|st_wr)     pend_q[f] <= base[f];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_flag <= 1'b0;
      upd_req   <= 1'b0;
    end else begin
      if (|st_wr)      pend_flag <= 1'b1;
      else if (commit) pend_flag <= 1'b0;
      if (upd_set)     upd_req   <= 1'b1;
      else if (commit) upd_req   <= 1'b0;
    end
  end

  // R8
  upd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req && engines_idle && !upd_set) |=> !upd_req);

  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_flag && !upd_req) |=> pend_flag);
endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_cfg_pkg::*;
#(
  parameter bit COMPAT = 1'b0,
  parameter int AW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic              txf_nonempty,
  output logic              busy,
  output logic [2*DATA_W-1:0] divisor,
  output logic [DATA_W-2:0] frame_fmt,
  output logic              loopback,
  output logic [DATA_W-1:0] int_enable
);
  cfg_t              act_q;
  cfg_t              vis;
  logic [DATA_W-1:0] ier_q, mcr_q;
  logic              cab_q, stage_en, gate, engines_idle;
  logic [NFIELD-1:0] st_wr, dw_wr;
  logic              hit_ier, hit_mcr, hit_ext, upd_set;
  logic              pend_flag, upd_req, commit, acc;

  uart_cfg_busy #(.COMPAT(COMPAT)) u_busy (
    .tx_active(tx_active), .rx_active(rx_active), .txf_nonempty(txf_nonempty),
    .busy(busy), .gate(gate), .engines_idle(engines_idle)
  );

  generate
    if (COMPAT) begin : g_nostage
      assign stage_en = 1'b0;
    end else begin : g_stage
      assign stage_en = cab_q;
    end
  endgenerate

  assign acc = vis[F_LCR][LCR_ACC_BIT];

  uart_cfg_decode #(.AW(AW)) u_dec (
    .wr(bus_wr), .addr(bus_addr), .acc(acc), .stage_en(stage_en), .gate(gate),
    .st_wr(st_wr), .dw_wr(dw_wr), .hit_ier(hit_ier), .hit_mcr(hit_mcr), .hit_ext(hit_ext)
  );

  assign upd_set = hit_ext && stage_en_req(bus_wdata);

  function automatic logic stage_en_req(input logic [DATA_W-1:0] d);
    return (COMPAT == 1'b0) && d[EXT_CAB_BIT] && d[EXT_UPD_BIT];
  endfunction

  uart_cfg_stage u_stage (
    .clk(clk), .rst_n(rst_n), .act(act_q), .st_wr(st_wr), .wdata(bus_wdata),
    .upd_set(upd_set), .engines_idle(engines_idle), .vis(vis),
    .pend_flag(pend_flag), .upd_req(upd_req), .commit(commit)
  );

  generate
    for (genvar f = 0; f < NFIELD; f++) begin : g_act
      always_ff @(posedge clk) begin
        if (!rst_n)        act_q[f] <= '0;
        else if (commit)   act_q[f] <= vis[f];
        else if (dw_wr[f]) act_q[f] <= bus_wdata;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q <= '0;
      mcr_q <= '0;
      cab_q <= 1'b0;
    end else begin
      if (hit_ier) ier_q <= bus_wdata;
      if (hit_mcr) mcr_q <= bus_wdata;
      if (hit_ext) cab_q <= bus_wdata[EXT_CAB_BIT];
    end
  end

  assign divisor    = {act_q[F_DLH], act_q[F_DLL]};
  assign frame_fmt  = act_q[F_LCR][DATA_W-2:0];
  assign loopback   = mcr_q[MCR_LOOP_BIT];
  assign int_enable = ier_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(A_DLL_DAT): bus_rdata = acc ? vis[F_DLL] : '0;
      AW'(A_DLH_IER): bus_rdata = acc ? vis[F_DLH] : ier_q;
      AW'(A_LCR):     bus_rdata = vis[F_LCR];
      AW'(A_MCR):     bus_rdata = mcr_q;
      AW'(A_EXT): begin
        bus_rdata[EXT_CAB_BIT] = cab_q;
        bus_rdata[EXT_UPD_BIT] = upd_req;
      end
      AW'(A_STAT):    bus_rdata[0] = busy;
      default:        bus_rdata = '0;
    endcase
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (divisor == '0 && frame_fmt == '0 && int_enable == '0 &&
                      !loopback && !cab_q && !pend_flag && !upd_req));

  // R3
  blocked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate && !stage_en && !commit) |=> $stable(act_q));

  // R6
  ier_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(A_DLH_IER) && acc) |=> $stable(int_enable));

  // R9
  commit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_q) && $past(dw_wr) == '0) |-> $past(!tx_active && !rx_active));

  // R10
  loop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(A_MCR)) |=> loopback == $past(bus_wdata[MCR_LOOP_BIT]));
endmodule

// File: tb/uart_cfg_regs_test.sv
module uart_cfg_regs_test;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic tx_active = 1'b0, rx_active = 1'b0, txf_nonempty = 1'b0;
  logic [7:0] bus_rdata, int_enable, c_rdata, c_ier;
  logic busy, loopback, c_busy, c_loop;
  logic [15:0] divisor, c_div;
  logic [6:0] frame_fmt, c_fmt;

  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] m_lcr, m_dll, m_dlh, m_ier, m_mcr, p_lcr, p_dll, p_dlh;
  logic m_cab, m_pf, m_upd;

  always #(CLK_P/2) clk = ~clk;

  uart_cfg_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .tx_active(tx_active), .rx_active(rx_active),
    .txf_nonempty(txf_nonempty), .busy(busy), .divisor(divisor), .frame_fmt(frame_fmt),
    .loopback(loopback), .int_enable(int_enable)
  );

  uart_cfg_regs #(.COMPAT(1'b1)) uut_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(c_rdata), .tx_active(tx_active), .rx_active(rx_active),
    .txf_nonempty(txf_nonempty), .busy(c_busy), .divisor(c_div), .frame_fmt(c_fmt),
    .loopback(c_loop), .int_enable(c_ier)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    {m_lcr, m_dll, m_dlh, m_ier, m_mcr, p_lcr, p_dll, p_dlh} = '0;
    {m_cab, m_pf, m_upd} = '0;
  endtask

  function automatic logic [7:0] model_read(input logic [2:0] a, input logic bsy);
    logic [7:0] vl = m_pf ? p_lcr : m_lcr;
    logic [7:0] vll = m_pf ? p_dll : m_dll;
    logic [7:0] vlh = m_pf ? p_dlh : m_dlh;
    case (a)
      3'd0: return vl[7] ? vll : 8'h00;
      3'd1: return vl[7] ? vlh : m_ier;
      3'd3: return vl;
      3'd4: return m_mcr;
      3'd5: return {6'b0, m_upd, m_cab};
      3'd7: return {7'b0, bsy};
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_edge(input logic [2:0] a, input logic w, input logic [7:0] d,
                            input logic t, input logic r, input logic f);
    logic [7:0] vl = m_pf ? p_lcr : m_lcr;
    logic [7:0] vll = m_pf ? p_dll : m_dll;
    logic [7:0] vlh = m_pf ? p_dlh : m_dlh;
    logic acc = vl[7];
    logic bsy = t | r | f;
    logic h_l = w && a == 3'd3;
    logic h_lo = w && a == 3'd0 && acc;
    logic h_hi = w && a == 3'd1 && acc;
    logic anyh = h_l | h_lo | h_hi;
    logic com = m_upd && !t && !r;
    logic n_cab = m_cab, n_pf = m_pf, n_upd = m_upd;
    logic [7:0] n_lcr = m_lcr, n_dll = m_dll, n_dlh = m_dlh;
    logic [7:0] q_lcr = p_lcr, q_dll = p_dll, q_dlh = p_dlh;
    if (com) begin
      n_lcr = vl; n_dll = vll; n_dlh = vlh; n_pf = 1'b0; n_upd = 1'b0;
    end else if (!m_cab && !bsy) begin
      if (h_l) n_lcr = d;
      if (h_lo) n_dll = d;
      if (h_hi) n_dlh = d;
    end
    if (m_cab && anyh) begin
      q_lcr = h_l ? d : vl;
      q_dll = h_lo ? d : vll;
      q_dlh = h_hi ? d : vlh;
      n_pf = 1'b1;
    end
    if (w && a == 3'd1 && !acc) m_ier = d;
    if (w && a == 3'd4) m_mcr = d;
    if (w && a == 3'd5) begin
      n_cab = d[0];
      if (d[0] && d[1]) n_upd = 1'b1;
    end
    {m_lcr, m_dll, m_dlh, p_lcr, p_dll, p_dlh} = {n_lcr, n_dll, n_dlh, q_lcr, q_dll, q_dlh};
    {m_cab, m_pf, m_upd} = {n_cab, n_pf, n_upd};
  endtask

  // Starts and ends just after a falling edge.
  task automatic step(input logic [2:0] a, input logic w, input logic [7:0] d,
                      input logic t, input logic r, input logic f);
    bus_addr = a; bus_wr = w; bus_wdata = d;
    tx_active = t; rx_active = r; txf_nonempty = f;
    #1;
    chk("R7 read path", bus_rdata, model_read(a, t | r | f));
    chk("R2 busy pin", busy, t | r | f);
    @(posedge clk);
    model_edge(a, w, d, t, r, f);
    @(negedge clk);
    bus_wr = 1'b0;
    chk("R4 divisor", divisor, {m_dlh, m_dll});
    chk("R4 frame format", frame_fmt, m_lcr[6:0]);
    chk("R10 loopback", loopback, m_mcr[4]);
    chk("R5 int enable", int_enable, m_ier);
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    bus_wr = 1'b0; bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [2:0] alist [6];
    void'($urandom(32'd4242));
    alist = '{3'd0, 3'd1, 3'd3, 3'd4, 3'd5, 3'd7};
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 divisor", divisor, 16'h0);
    chk("R1 frame", frame_fmt, 7'h0);
    rd(3'd5, v); chk("R1 ext", v, 8'h00);
    rd(3'd7, v); chk("R1 status", v, 8'h00);
    rd(3'd1, v); chk("R1 ier", v, 8'h00);

    // R4 idle direct writes
    step(3'd3, 1, 8'h80, 0, 0, 0);
    step(3'd0, 1, 8'h34, 0, 0, 0);
    step(3'd1, 1, 8'h12, 0, 0, 0);
    chk("R4 divisor 1234", divisor, 16'h1234);

    // R3 blocked by tx, and by fifo alone; R11 compat instance takes them
    step(3'd0, 1, 8'hAA, 1, 0, 0);
    chk("R3 tx blocks divisor", divisor, 16'h1234);
    chk("R11 compat divisor", c_div, 16'h12AA);
    step(3'd3, 1, 8'h03, 0, 0, 1);
    chk("R3 fifo blocks frame", frame_fmt, 7'h00);
    chk("R11 compat frame", c_fmt, 7'h03);

    // R6 blocked divisor-high write does not reach interrupt enable
    step(3'd1, 1, 8'h55, 0, 1, 0);
    chk("R6 ier untouched", int_enable, 8'h00);
    chk("R3 rx blocks divisor", divisor, 16'h1234);
    // R5 access bit clear: address 1 is interrupt enable, writable while busy
    step(3'd3, 1, 8'h03, 0, 0, 0);
    step(3'd1, 1, 8'h0F, 1, 0, 0);
    chk("R5 ier write", int_enable, 8'h0F);
    rd(3'd0, v); chk("R5 addr0 reads zero", v, 8'h00);

    // R2 and R10: loopback set while receiving keeps busy
    step(3'd4, 1, 8'h10, 0, 1, 0);
    chk("R10 loopback set", loopback, 1'b1);
    rd(3'd7, v); chk("R10 busy stays with rx", v, 8'h01);
    chk("R2 busy pin rx", busy, 1'b1);

    // R7 staging
    step(3'd5, 1, 8'h01, 0, 1, 0);
    step(3'd3, 1, 8'h80, 1, 0, 0);
    chk("R7 frame not applied", frame_fmt, 7'h03);
    rd(3'd3, v); chk("R7 pending readback", v, 8'h80);
    step(3'd0, 1, 8'h08, 1, 0, 0);
    step(3'd1, 1, 8'h00, 1, 0, 0);
    chk("R7 divisor not applied", divisor, 16'h1234);
    rd(3'd0, v); chk("R7 pending divisor low", v, 8'h08);

    // R8 and R9 update request held while tx runs, released with fifo busy only
    step(3'd5, 1, 8'h03, 1, 0, 0);
    step(3'd7, 0, 8'h00, 1, 0, 0);
    chk("R9 no commit while tx", divisor, 16'h1234);
    rd(3'd5, v); chk("R8 update bit set", v, 8'h03);
    step(3'd7, 0, 8'h00, 0, 0, 1);
    chk("R9 commit at idle", divisor, 16'h0008);
    chk("R9 frame commit", frame_fmt, 7'h00);
    rd(3'd5, v); chk("R8 update cleared", v, 8'h01);

    // Seeded random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a = alist[$urandom % 6];
      logic w = ($urandom % 3) != 0;
      logic [7:0] d = (a == 3'd5) ? 8'($urandom % 4) : 8'($urandom);
      logic t = ($urandom % 4) == 0;
      logic r = ($urandom % 4) == 0;
      logic f = ($urandom % 5) == 0;
      step(a, w, d, t, r, f);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule